// File: doc/BRIEF.md
# Pointer-Based I2C Register Target

This block is an I2C target that runs entirely on a fast system clock. It oversamples the bus lines through a short synchronizer. From the synchronized lines it finds START, repeated START and STOP, and it matches a 7-bit device address. The upper four address bits are fixed. The lower three come from strap inputs, so up to eight copies can share one bus.

After its address is acknowledged in a write, the first byte the block takes is a command byte. The two low bits of that byte set a register pointer. Every later byte in the same write goes to the register the pointer selects. Each such byte is delivered through a simple register port that has an address, write data and a one-cycle write strobe.

A read sends the selected register, most significant bit first. The block keeps sending the same register for as long as the master acknowledges. The pointer never increments, and it keeps its value from one transaction to the next. The block drives SDA only as an open-drain pull-down enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0011 followed by `addr_pins[2:0]`. Bit 0 of that byte is the direction: 1 means read and 0 means write. Any other address gets no acknowledge. In that case the block drives nothing and issues no strobe until the next START.
- R2: Every byte the block receives (a matching address, the command byte and each write data byte) is acknowledged. The block pulls SDA low from the SCL low period after the eighth bit until SCL falls at the end of the ninth clock. It then releases SDA.
- R3: Bits [1:0] of the command byte become the register pointer, and bits [7:2] are ignored. `reg_addr` always shows the pointer.
- R4: Each write data byte produces exactly one single-cycle `reg_wr` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The pulse comes after SCL falls at the end of that byte's acknowledge clock. Several bytes in one write all go to the same address.
- R5: A data byte cut short by STOP before its acknowledge clock has completed produces no `reg_wr` pulse.
- R6: On a read, `reg_rd` pulses for one cycle and the block captures `reg_rdata` in that cycle. It then shifts the captured byte onto SDA, most significant bit first, one bit per SCL clock.
- R7: The pointer does not auto-increment and is kept across transactions. Every byte of a read, and every later read, returns the register the last command byte selected.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays released. It issues no further `reg_rd` until the next START.
- R9: A repeated START at any bit position abandons the current byte and returns the block to address matching.
- R10: The asynchronous active-low reset releases SDA, clears the pointer to 0 and holds both strobes low.
- R11: A combined transfer works as follows: a write of only the command byte, then a repeated START with the direction bit at 1. The read returns the newly selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (the wired bus value) |
| sda_oe | output | 1 | When 1, pull SDA low |
| addr_pins | input | 3 | Strap bits for the low three address bits |
| reg_addr | output | 2 | Register pointer |
| reg_wdata | output | 8 | Data for a register write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, sampled while `reg_rd` is high |
| reg_rd | output | 1 | One-cycle read strobe |

## Verification
The bench targets these failure points:
- A data byte cut off by STOP or by a repeated START part-way through its bits. A design that writes on the eighth bit, or that does not reset its bit count, would emit a spurious write or would misalign the next address.
- A pointer set by a command byte with its upper bits set. A design that keeps the full byte, or that increments after each byte, would return the wrong register on the second and later bytes of a read, or in a fresh read transaction.
- A master NACK followed by an extra clock. A design that keeps transmitting would pull SDA low or fetch another byte.
- A wrong strap address. A design that ignores the straps would acknowledge it.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [3:0] ADDR_HI = 4'b0011,
  parameter int PIN_W = 3,
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [PIN_W-1:0] addr_pins,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_wr,
  input  logic [DW-1:0]   reg_rdata,
  output logic            reg_rd
);

  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST = BCW'(DW);
  localparam logic [BCW-1:0] LAST_TX = BCW'(DW - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WR, S_WACK, S_RD, S_MACK
  } st_t;

  logic [SYNC-1:0] scl_q, sda_q;
  logic            scl_d, sda_d;
  logic            scl_s, sda_s;
  logic            scl_rise, scl_fall, start_c, stop_c;

  st_t             st;
  logic [DW-1:0]   sr;
  logic [BCW-1:0]  bcnt;
  logic            rw_q, mack_q, oe_q, wr_q, rd_q;
  logic [AW-1:0]   ptr_q;
  logic [DW-1:0]   wdata_q;
  logic            addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_d <= scl_q[SYNC-1];
      sda_d <= sda_q[SYNC-1];
    end
  end

  assign scl_s    = scl_q[SYNC-1];
  assign sda_s    = sda_q[SYNC-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign addr_hit = (sr[DW-1:1] == {ADDR_HI, addr_pins});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sr      <= '0;
      bcnt    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      ptr_q   <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (start_c) begin
        st   <= S_ADDR;
        bcnt <= '0;
        oe_q <= 1'b0;
      end else if (stop_c) begin
        st   <= S_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WR: begin
            if (scl_rise) begin
              sr   <= {sr[DW-2:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == LAST) begin
              bcnt <= '0;
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  rw_q <= sr[0];
                  oe_q <= 1'b1;
                  st   <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                ptr_q <= sr[AW-1:0];
                oe_q  <= 1'b1;
                st    <= S_CACK;
              end else begin
                wdata_q <= sr;
                oe_q    <= 1'b1;
                st      <= S_WACK;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              if (rw_q) begin
                rd_q <= 1'b1;
                st   <= S_RD;
              end else begin
                st <= S_CMD;
              end
            end
          end
          S_CACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              st   <= S_WR;
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              wr_q <= 1'b1;
              st   <= S_WR;
            end
          end
          S_RD: begin
            if (rd_q) begin
              sr   <= reg_rdata;
              oe_q <= ~reg_rdata[DW-1];
            end else if (scl_fall) begin
              if (bcnt == LAST_TX) begin
                bcnt <= '0;
                oe_q <= 1'b0;
                st   <= S_MACK;
              end else begin
                bcnt <= bcnt + 1'b1;
                sr   <= {sr[DW-2:0], 1'b0};
                oe_q <= ~sr[DW-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                rd_q <= 1'b1;
                st   <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_wr,
  input logic reg_rd
);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_wr_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !scl_i);

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;
  localparam int T = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [4];
  wire line = m_sda & ~sda_oe;
  int checks = 0, errors = 0, rd_seen = 0;
  logic [9:0] exp_q [$];

  always #2.5 clk = ~clk;

  i2c_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line), .sda_oe(sda_oe),
    .addr_pins(pins), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .reg_rd(reg_rd)
  );

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) if (reg_wr) regs[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      if (exp_q.size() == 0) chk(0, "R4/R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R4 write", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_rd) rd_seen++;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart; m_sda = 1; m_scl = 1; tick(T); m_sda = 0; tick(T); m_scl = 0; tick(T); endtask
  task automatic brstart; m_sda = 1; tick(T); m_scl = 1; tick(T); m_sda = 0; tick(T); m_scl = 0; tick(T); endtask
  task automatic bstop; m_sda = 0; tick(T); m_scl = 1; tick(T); m_sda = 1; tick(T); endtask
  task automatic send_bit(input logic b); m_sda = b; tick(T); m_scl = 1; tick(T); m_scl = 0; tick(2); endtask
  task automatic recv_bit(output logic r);
    m_sda = 1; tick(T); m_scl = 1; tick(T/2); r = line; tick(T/2); m_scl = 0; tick(2);
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    ack = !r;
  endtask
  task automatic rbyte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      recv_bit(r);
      b[i] = r;
    end
    send_bit(!mack);
  endtask

  localparam logic [6:0] DEV = {4'b0011, 3'b101};
  initial begin
    logic a;
    logic [7:0] d;
    logic r;
    regs[0] = 8'h5A; regs[1] = 8'h00; regs[2] = 8'hF0; regs[3] = 8'h96;
    tick(1); rst_n = 0; tick(4);
    chk(sda_oe == 0, "R10 sda released", sda_oe, 0);
    chk(reg_addr == 0, "R10 pointer", reg_addr, 0);
    chk(!reg_wr && !reg_rd, "R10 strobes", {reg_wr, reg_rd}, 0);
    rst_n = 1; tick(4);

    // R1 R2 R3 R4: command with upper bits set, two data bytes
    exp_q.push_back({2'd1, 8'hA5}); exp_q.push_back({2'd1, 8'h3C});
    bstart; wbyte({DEV, 1'b0}, a); chk(a, "R1 address ack", a, 1);
    wbyte(8'hFD, a); chk(a, "R2 command ack", a, 1);
    chk(reg_addr == 1, "R3 pointer from low bits", reg_addr, 1);
    wbyte(8'hA5, a); chk(a, "R2 data ack", a, 1);
    wbyte(8'h3C, a); chk(a, "R4 second data ack", a, 1);
    bstop;
    chk(regs[1] == 8'h3C, "R4 register updated", regs[1], 8'h3C);

    // R11 R6 R7 R8: combined read of register 3
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'h03, a);
    brstart; wbyte({DEV, 1'b1}, a); chk(a, "R11 read address ack", a, 1);
    rbyte(1, d); chk(d == 8'h96, "R11 first byte", d, 8'h96);
    rbyte(1, d); chk(d == 8'h96, "R7 no increment", d, 8'h96);
    rbyte(0, d); chk(d == 8'h96, "R6 last byte", d, 8'h96);
    recv_bit(r); chk(r == 1, "R8 released after nack", r, 1);
    bstop;
    chk(rd_seen == 3, "R8 read strobe count", rd_seen, 3);

    // R7: new read, pointer held
    bstart; wbyte({DEV, 1'b1}, a);
    rbyte(1, d); chk(d == 8'h96, "R7 held pointer", d, 8'h96);
    rbyte(0, d); chk(d == 8'h96, "R7 held pointer 2", d, 8'h96);
    bstop;
    chk(reg_addr == 3, "R7 pointer kept", reg_addr, 3);

    // R1: wrong strap address ignored
    bstart; wbyte({4'b0011, 3'b100, 1'b0}, a); chk(!a, "R1 mismatch no ack", a, 0);
    wbyte(8'h02, a); chk(!a, "R1 idle after mismatch", a, 0);
    wbyte(8'h11, a);
    bstop;
    chk(reg_addr == 3, "R1 mismatch left pointer", reg_addr, 3);

    // R5: STOP mid data byte
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'h02, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bstop;
    chk(regs[2] == 8'hF0, "R5 no write on cut byte", regs[2], 8'hF0);
    chk(reg_addr == 2, "R3 pointer 2", reg_addr, 2);

    // R9: repeated START mid data byte
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    brstart; wbyte({DEV, 1'b1}, a); chk(a, "R9 address after abort", a, 1);
    rbyte(0, d); chk(d == 8'h5A, "R9 read after abort", d, 8'h5A);
    bstop;
    chk(regs[0] == 8'h5A, "R9 no write", regs[0], 8'h5A);
    chk(rd_seen == 6, "R6 total read strobes", rd_seen, 6);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    tick(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule